// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

The sequencer is the digital core of an 8-bit successive-approximation converter. It runs on a free-running conversion clock. A start request arrives from the serial interface domain after that interface has received a full transfer, along with a 4-bit channel address. On the start request the sequencer clears its end-of-conversion flag and captures the channel. It then steers the analog multiplexer and walks a trial code on the DAC, from the most significant bit down. For each bit it reads one decision from an external comparator.

Every conversion takes a fixed frame of 20 conversion clocks: four sampling clocks with the DAC at zero, then two clocks per result bit. At the end of the frame the result register is loaded and the flag rises. Channel codes above the last analog input route the multiplexer to an internal mid-scale test level, which converts to 0x80 on a working converter. An interface reset arriving during a frame abandons it. In that case the result register keeps its old value and the flag stays low.

Top module: `sar_conv_seq`

## Requirements
- R1: While rst_ni is low and after its release, eoc_o is 1, result_o is 0x00, dac_code_o is 0x00 and mux_sel_o is 0x0.
- R2: start_req_i passes through a two-flop synchroniser and a rising-edge detector. eoc_o is low on the third rising clock edge after start_req_i rises, and chan_i is captured on that same edge.
- R3: eoc_o returns high exactly 20 clock edges after it fell, so the rise lands on the 23rd edge after start_req_i rose.
- R4: In frame clocks 0 to 3, dac_code_o is 0x00. In frame clocks 4+2j and 5+2j (j = 0 to 7), dac_code_o holds the bits already kept, plus bit 7-j set to 1, with every lower bit at 0.
- R5: At the end of frame clock 5+2j, the trial bit 7-j is kept only if cmp_i is 1, which means input ≥ DAC level. The final result is therefore the largest code whose DAC level does not exceed the input.
- R6: The result register loads at the end of the frame. An input at the upper reference gives 0xFF, and an input at the lower reference gives 0x00.
- R7: Channel codes 0x0 to 0xA appear unchanged on mux_sel_o. Codes 0xB to 0xF drive mux_sel_o to 0xB, the mid-scale test level, which converts to 0x80.
- R8: A rising edge of abort_req_i, after the same two-flop synchronisation, ends a running frame. In that case result_o is unchanged and eoc_o stays low. In a cycle where both edges are detected, the abort takes priority over a start.
- R9: A start edge during a running frame is ignored. The frame length, the captured channel and the result all stay those of the running conversion.
- R10: Outside a frame, dac_code_o is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running conversion clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_req_i | input | 1 | Start request from the interface clock domain; a rising edge starts a conversion |
| abort_req_i | input | 1 | Interface reset from the interface clock domain; a rising edge aborts a conversion |
| chan_i | input | 4 | Channel address, held stable around the start request |
| cmp_i | input | 1 | Comparator decision: 1 when the input is ≥ the DAC level |
| dac_code_o | output | 8 | Trial code applied to the DAC |
| mux_sel_o | output | 4 | Analog multiplexer select (0xB is the test level) |
| result_o | output | 8 | Last completed conversion result |
| eoc_o | output | 1 | End-of-conversion flag, high when a result is ready |

## Verification
The hardest states to reach are those where request edges collide with a running frame: an abort in the middle of the bit steps, a start edge and an abort edge detected in the same cycle, and a second start edge while the frame is still running. The stimulus reaches each of these by timing its request pulses in clock counts from the previous start rise. It also changes the channel and the analog inputs between requests, so that any leak from a rejected request shows up in the multiplexer select or in the result. A behavioural comparator is driven from the multiplexer select and a numeric voltage per channel. This makes every step decision depend on earlier kept bits, and values such as 127 and 123 exercise mixed keep and drop patterns.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int DATA_W      = 8;
  localparam int CHAN_W      = 4;
  localparam int SAMPLE_CYC  = 4;
  localparam int STEP_CYC    = 2;
  localparam int NUM_INPUTS  = 11;
  localparam int TEST_CHAN   = 11;
  localparam int SYNC_STAGES = 2;
  localparam int FRAME_CYC   = SAMPLE_CYC + DATA_W * STEP_CYC;
  localparam int STEP_W      = $clog2(DATA_W);
endpackage

// File: rtl/sar_sync_edge.sv
module sar_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[0] <= 1'b0;
        else         sync_q[0] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= 1'b0;
        else         sync_q[i] <= sync_q[i-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/sar_frame_ctrl.sv
module sar_frame_ctrl #(
  parameter int DATA_W     = 8,
  parameter int SAMPLE_CYC = 4,
  parameter int STEP_CYC   = 2,
  parameter int STEP_W     = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  output logic              busy_o,
  output logic              go_o,
  output logic              trial_o,
  output logic              decide_o,
  output logic              done_o,
  output logic              eoc_o,
  output logic [STEP_W-1:0] step_o
);
  localparam int FRAME_CYC = SAMPLE_CYC + DATA_W * STEP_CYC;
  localparam int CNT_W     = $clog2(FRAME_CYC);
  localparam logic [CNT_W-1:0] SAMPLE_C = CNT_W'(SAMPLE_CYC);
  localparam logic [CNT_W-1:0] STEP_C   = CNT_W'(STEP_CYC);
  localparam logic [CNT_W-1:0] LAST_C   = CNT_W'(FRAME_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] offs;
  logic             busy_q;
  logic             eoc_q;
  logic             last;

  assign offs     = cnt_q - SAMPLE_C;
  assign trial_o  = busy_q && (cnt_q >= SAMPLE_C);
  assign step_o   = STEP_W'(offs / STEP_C);
  // decision is taken on the last clock of each step
  assign decide_o = trial_o && ((offs % STEP_C) == (STEP_C - CNT_W'(1)));
  assign last     = busy_q && (cnt_q == LAST_C);
  assign go_o     = start_i && !busy_q && !abort_i;
  assign done_o   = last && !abort_i;
  assign busy_o   = busy_q;
  assign eoc_o    = eoc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (last) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     eoc_q <= 1'b1;
    else if (go_o)   eoc_q <= 1'b0;
    else if (done_o) eoc_q <= 1'b1;
  end
endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
  parameter int DATA_W = 8,
  parameter int STEP_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              busy_i,
  input  logic              trial_i,
  input  logic              decide_i,
  input  logic              done_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              cmp_i,
  output logic [DATA_W-1:0] dac_code_o,
  output logic [DATA_W-1:0] result_o
);
  localparam logic [STEP_W-1:0] TOP_BIT = STEP_W'(DATA_W - 1);

  logic [DATA_W-1:0] kept_q;
  logic [DATA_W-1:0] result_q;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] trial_code;

  assign mask       = trial_i ? (DATA_W'(1) << (TOP_BIT - step_i)) : '0;
  assign trial_code = kept_q | mask;
  assign dac_code_o = busy_i ? trial_code : '0;
  assign result_o   = result_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 kept_q <= '0;
    else if (go_i)               kept_q <= '0;
    else if (decide_i && cmp_i)  kept_q <= trial_code;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     result_q <= '0;
    else if (done_i) result_q <= cmp_i ? trial_code : kept_q;
  end
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_pkg::*;
#(
  parameter int P_DATA_W      = DATA_W,
  parameter int P_CHAN_W      = CHAN_W,
  parameter int P_SAMPLE_CYC  = SAMPLE_CYC,
  parameter int P_STEP_CYC    = STEP_CYC,
  parameter int P_NUM_INPUTS  = NUM_INPUTS,
  parameter int P_TEST_CHAN   = TEST_CHAN,
  parameter int P_SYNC_STAGES = SYNC_STAGES
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_req_i,
  input  logic                abort_req_i,
  input  logic [P_CHAN_W-1:0] chan_i,
  input  logic                cmp_i,
  output logic [P_DATA_W-1:0] dac_code_o,
  output logic [P_CHAN_W-1:0] mux_sel_o,
  output logic [P_DATA_W-1:0] result_o,
  output logic                eoc_o
);
  localparam int P_STEP_W = $clog2(P_DATA_W);

  logic                start_rise;
  logic                abort_rise;
  logic                busy;
  logic                go;
  logic                trial;
  logic                decide;
  logic                done;
  logic [P_STEP_W-1:0] step;
  logic [P_CHAN_W-1:0] chan_q;

  sar_sync_edge #(.STAGES(P_SYNC_STAGES)) u_start_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(start_req_i),
    .rise_o (start_rise)
  );

  sar_sync_edge #(.STAGES(P_SYNC_STAGES)) u_abort_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(abort_req_i),
    .rise_o (abort_rise)
  );

  sar_frame_ctrl #(
    .DATA_W    (P_DATA_W),
    .SAMPLE_CYC(P_SAMPLE_CYC),
    .STEP_CYC  (P_STEP_CYC),
    .STEP_W    (P_STEP_W)
  ) u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_rise),
    .abort_i (abort_rise),
    .busy_o  (busy),
    .go_o    (go),
    .trial_o (trial),
    .decide_o(decide),
    .done_o  (done),
    .eoc_o   (eoc_o),
    .step_o  (step)
  );

  sar_approx_reg #(
    .DATA_W(P_DATA_W),
    .STEP_W(P_STEP_W)
  ) u_sar (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (go),
    .busy_i    (busy),
    .trial_i   (trial),
    .decide_i  (decide),
    .done_i    (done),
    .step_i    (step),
    .cmp_i     (cmp_i),
    .dac_code_o(dac_code_o),
    .result_o  (result_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  chan_q <= '0;
    else if (go)  chan_q <= chan_i;
  end

  // every code above the last analog input routes to the test level
  assign mux_sel_o = (chan_q < P_CHAN_W'(P_NUM_INPUTS)) ? chan_q : P_CHAN_W'(P_TEST_CHAN);
endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
  parameter int DATA_W    = 8,
  parameter int CHAN_W    = 4,
  parameter int FRAME     = 20,
  parameter int TEST_CHAN = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic              eoc_i,
  input logic [DATA_W-1:0] dac_i,
  input logic [CHAN_W-1:0] mux_i,
  input logic [DATA_W-1:0] result_i
);
  localparam int RW = $clog2(FRAME + 1) + 1;

  logic [RW-1:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_cnt <= '0;
    else if (busy_i) run_cnt <= run_cnt + RW'(1);
    else             run_cnt <= '0;
  end

  assert_start_clears_eoc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> !eoc_i);

  assert_frame_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eoc_i) |-> run_cnt == RW'(FRAME));

  assert_frame_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> run_cnt < RW'(FRAME));

  assert_sample_dac_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> dac_i == '0);

  assert_mux_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mux_i <= CHAN_W'(TEST_CHAN));

  assert_result_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(eoc_i) |-> $stable(result_i));

  assert_mux_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(mux_i));
endmodule

bind sar_conv_seq sar_conv_seq_chk #(
  .DATA_W   (P_DATA_W),
  .CHAN_W   (P_CHAN_W),
  .FRAME    (P_SAMPLE_CYC + P_DATA_W * P_STEP_CYC),
  .TEST_CHAN(P_TEST_CHAN)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .busy_i  (busy),
  .eoc_i   (eoc_o),
  .dac_i   (dac_code_o),
  .mux_i   (mux_sel_o),
  .result_i(result_o)
);

// File: tb/sar_conv_seq_bench.sv
module sar_conv_seq_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_req = 1'b0;
  logic       abort_req = 1'b0;
  logic [3:0] chan = 4'h0;
  logic       cmp;
  logic [7:0] dac_code;
  logic [3:0] mux_sel;
  logic [7:0] result;
  logic       eoc;

  int n_chk = 0;
  int n_err = 0;
  bit run_cmp = 1'b0;
  int vin_tab [0:10];

  always #4 clk = ~clk;

  sar_conv_seq u_sar_conv_seq (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .start_req_i(start_req),
    .abort_req_i(abort_req),
    .chan_i     (chan),
    .cmp_i      (cmp),
    .dac_code_o (dac_code),
    .mux_sel_o  (mux_sel),
    .result_o   (result),
    .eoc_o      (eoc)
  );

  // analog model: 10 units per LSB, test level at code 128
  int sel_v;
  always_comb begin
    sel_v = (mux_sel <= 4'd10) ? vin_tab[mux_sel] : 1280;
    cmp   = (sel_v >= int'(dac_code) * 10);
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  int m_busy = 0, m_k = 0, m_eoc = 1, m_res = 0, m_chan = 0, m_final = 0;
  int s1 = 0, s2 = 0, s3 = 0, a1 = 0, a2 = 0, a3 = 0;

  function automatic int ideal(input int ch);
    int v;
    if (ch > 10) return 128;
    v = vin_tab[ch] / 10;
    return (v > 255) ? 255 : v;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_k = 0; m_eoc = 1; m_res = 0; m_chan = 0;
      s1 = 0; s2 = 0; s3 = 0; a1 = 0; a2 = 0; a3 = 0;
    end else begin
      bit sp, ap;
      sp = (s2 == 1) && (s3 == 0);
      ap = (a2 == 1) && (a3 == 0);
      if (ap) begin
        m_busy = 0;
      end else if (m_busy == 1) begin
        if (m_k == 19) begin
          m_res = m_final; m_eoc = 1; m_busy = 0;
        end else m_k++;
      end else if (sp) begin
        m_busy = 1; m_k = 0; m_eoc = 0; m_chan = int'(chan);
        m_final = ideal(m_chan);
      end
      s3 = s2; s2 = s1; s1 = int'(start_req);
      a3 = a2; a2 = a1; a1 = int'(abort_req);
    end
  end

  always @(negedge clk) begin
    if (run_cmp && rst_ni) begin
      int exp_dac, j;
      exp_dac = 0;
      if (m_busy == 1 && m_k >= 4) begin
        j = (m_k - 4) / 2;
        exp_dac = (m_final & (~(255 >> j)) & 255) | (128 >> j);
      end
      chk("R4 dac_code", int'(dac_code), exp_dac);
      chk("R3 eoc", int'(eoc), m_eoc);
      chk("R6 result", int'(result), m_res);
      chk("R7 mux_sel", int'(mux_sel), (m_chan > 10) ? 11 : m_chan);
    end
  end

  task automatic convert(input int ch, input int exp, input string tag);
    int cyc;
    @(negedge clk);
    chan = 4'(ch);
    start_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 eoc low after sync", int'(eoc), 0);
    cyc = 3;
    @(negedge clk);
    cyc++;
    start_req = 1'b0;
    while (!eoc && cyc < 60) begin
      @(negedge clk);
      cyc++;
    end
    chk("R3 frame length", cyc, 23);
    chk(tag, int'(result), exp);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    vin_tab = '{0, 25, 700, 1234, 1279, 2549, 900, 500, 60, 1500, 2550};
    repeat (3) @(negedge clk);
    chk("R1 eoc", int'(eoc), 1);
    chk("R1 result", int'(result), 0);
    chk("R1 dac_code", int'(dac_code), 0);
    chk("R1 mux_sel", int'(mux_sel), 0);
    rst_ni = 1'b1;
    run_cmp = 1'b1;
    repeat (2) @(negedge clk);

    convert(0, 0, "R6 lower reference");
    convert(10, 255, "R6 upper reference");
    convert(3, 123, "R5 mixed bits");
    convert(4, 127, "R5 just below midscale");
    convert(5, 254, "R5 near full scale");
    convert(11, 128, "R7 test channel");
    chk("R7 mux test", int'(mux_sel), 11);
    convert(14, 128, "R7 reserved code");
    chk("R7 mux reserved", int'(mux_sel), 11);
    chk("R10 idle dac", int'(dac_code), 0);

    // abort mid-frame
    @(negedge clk);
    chan = 4'd2;
    start_req = 1'b1;
    repeat (4) @(negedge clk);
    start_req = 1'b0;
    repeat (8) @(negedge clk);
    abort_req = 1'b1;
    repeat (3) @(negedge clk);
    abort_req = 1'b0;
    repeat (30) @(negedge clk);
    chk("R8 eoc after abort", int'(eoc), 0);
    chk("R8 result kept", int'(result), 128);
    chk("R10 dac after abort", int'(dac_code), 0);

    // start and abort detected together while idle
    chan = 4'd9;
    start_req = 1'b1;
    abort_req = 1'b1;
    repeat (4) @(negedge clk);
    start_req = 1'b0;
    abort_req = 1'b0;
    repeat (30) @(negedge clk);
    chk("R8 abort wins eoc", int'(eoc), 0);
    chk("R8 abort wins result", int'(result), 128);

    convert(6, 90, "R5 after abort");

    // second start during a frame
    begin
      int cyc;
      @(negedge clk);
      chan = 4'd3;
      start_req = 1'b1;
      cyc = 0;
      while (cyc < 60 && !(cyc > 4 && eoc)) begin
        @(negedge clk);
        cyc++;
        if (cyc == 4) start_req = 1'b0;
        if (cyc == 8) begin chan = 4'd7; start_req = 1'b1; end
        if (cyc == 11) start_req = 1'b0;
      end
      chk("R9 frame length", cyc, 23);
      chk("R9 result", int'(result), 123);
      chk("R9 mux_sel", int'(mux_sel), 3);
    end
    repeat (30) @(negedge clk);
    chk("R9 no second frame", int'(eoc), 1);

    finish_run();
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end
endmodule